// File: doc/BRIEF.md
# Bus clock run/stop controller

This block decides when a shared bus clock may be halted to save power and when it has to be brought back. It runs from a free-running clock. Three inputs report activity: bus cycles on the main or low-pin-count bus, internal requests that need the bus, and serial interrupt line activity. It also sees an active-low clock-request line that every peripheral shares. The block treats that line as an open-drain pad, with a drive value, an output enable and a raw sampled input. It drives an active-low clock-stop output to an external clock generator.

While the bus is busy, the block holds the request line low. After a run of idle clocks it drives the line high for a single clock and then lets go of it. This lets any peripheral claim the clock by pulling the line low again.

- If the line stays high through a fixed check window, the block asserts clock-stop.
- Once the clock is stopped, a low on the line (or new activity) brings the clock back. The release of clock-stop has a fixed latency, and the block resumes driving the line low.

The sampled line passes through a two-flop synchronizer. Every clock count given below is measured at the synchronizer output.

Top module: `bus_clk_gate_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, req_oe_o=1, req_drive_o=0 and clk_stop_no=1.
- R2: After 29 consecutive clocks with no activity input high, the block drives the line high (req_oe_o=1, req_drive_o=1) for exactly one clock. It then releases the line (req_oe_o=0).
- R3: Any of bus_cycle_i, int_req_i or serirq_act_i clears the idle count. A fresh run of 29 idle clocks is also required every time the block returns to driving the line low.
- R4: While clk_stop_no=1, a high int_req_i leaves the line actively driven low (req_oe_o=1, req_drive_o=0) in the next cycle.
- R5: If no veto arrives, clk_stop_no falls 7 clocks after the high-drive clock, which leaves 6 released clocks in between. It only falls while the line is released.
- R6: Veto. A low on the synchronized line during the check window returns the block to driving low on the next clock, and clk_stop_no stays 1. The synchronized value in the first window clock is stale and is ignored.
- R7: While stopped, a low on the synchronized line makes the block drive the line low one clock later, with clk_stop_no still 0. clk_stop_no returns to 1 exactly 2 clocks after the sampled low, which is 4 clocks after the low first appears at the pin.
- R8: Activity during the high-drive clock or during the check window aborts the stop sequence. The next cycle drives the line low with clk_stop_no=1.
- R9: While stopped, any activity input restarts the clock with the same timing as R7. The line is driven low after 1 clock and clk_stop_no=1 after 2 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_cycle_i | input | 1 | Main or low-pin-count bus cycle in progress |
| int_req_i | input | 1 | Internal device needs the bus |
| serirq_act_i | input | 1 | Serial interrupt line activity |
| req_line_i | input | 1 | Raw value of the shared clock-request line at the pad |
| req_drive_o | output | 1 | Value driven onto the request line when enabled |
| req_oe_o | output | 1 | Output enable for the request line pad |
| clk_stop_no | output | 1 | Clock-stop request to the clock generator, active low |

## Verification
The assertions assume that req_line_i follows open-drain behaviour. It reads low whenever the block drives low, it reads high when the block drives high, and it reads high when released unless a peripheral pulls it down. The bench enforces this with a wired-AND pad model and pulls the line down only while the block has released it. The assertions also assume that activity inputs are synchronous to the free-running clock. The random phase pulses one activity source at a time, then holds every input low for a random gap that ends before a stop could be issued. This keeps each idle period cleanly separated. Vetoes and restarts are applied as directed cases at known cycles.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,  // drive line low, count idle
    ST_DEASSERT = 3'd1,  // drive line high for one clock
    ST_CHECK    = 3'd2,  // released, watch for veto
    ST_STOP     = 3'd3,  // clock stopped
    ST_WAKE     = 3'd4   // drive low, clock still stopped
  } bcg_state_e;
endpackage

// File: rtl/bcg_sync.sv
module bcg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) pipe_q[0] <= RST_VAL;
          else         pipe_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) pipe_q[i] <= RST_VAL;
          else         pipe_q[i] <= pipe_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/bcg_idle_cnt.sv
module bcg_idle_cnt #(
  parameter int IDLE_CYC = 29
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic act_i,
  output logic expire_o
);
  localparam int CNT_W = $clog2(IDLE_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || act_i)   cnt_q <= '0;
    else if (cnt_q != LAST)     cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && !act_i && (cnt_q == LAST);
endmodule

// File: rtl/bcg_fsm.sv
module bcg_fsm
  import bcg_pkg::*;
#(
  parameter int CHK_CYC     = 6,
  parameter int WAKE_CYC    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idle_done_i,
  input  logic       act_i,
  input  logic       line_s_i,
  output bcg_state_e state_o
);
  localparam int WMAX  = (CHK_CYC > WAKE_CYC) ? CHK_CYC : WAKE_CYC;
  localparam int WIN_W = $clog2(WMAX + 1);
  localparam logic [WIN_W-1:0] CHK_LAST  = WIN_W'(CHK_CYC - 1);
  localparam logic [WIN_W-1:0] WAKE_LAST = WIN_W'(WAKE_CYC - 1);
  // first window clocks still show the line as it was while driven
  localparam logic [WIN_W-1:0] IGN_CNT   = WIN_W'(SYNC_STAGES - 1);

  bcg_state_e       state_q, state_d;
  logic [WIN_W-1:0] win_q, win_d;
  logic             veto;

  assign veto = (win_q >= IGN_CNT) && !line_s_i;

  always_comb begin
    state_d = state_q;
    win_d   = '0;
    unique case (state_q)
      ST_RUN: begin
        if (idle_done_i) state_d = ST_DEASSERT;
      end
      ST_DEASSERT: begin
        state_d = act_i ? ST_RUN : ST_CHECK;
      end
      ST_CHECK: begin
        if (act_i || veto)          state_d = ST_RUN;
        else if (win_q == CHK_LAST) state_d = ST_STOP;
        else                        win_d   = win_q + 1'b1;
      end
      ST_STOP: begin
        if (act_i || !line_s_i) state_d = ST_WAKE;
      end
      ST_WAKE: begin
        if (win_q == WAKE_LAST) state_d = ST_RUN;
        else                    win_d   = win_q + 1'b1;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      win_q   <= '0;
    end else begin
      state_q <= state_d;
      win_q   <= win_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/bus_clk_gate_ctrl.sv
module bus_clk_gate_ctrl
  import bcg_pkg::*;
#(
  parameter int IDLE_CYC    = 29,
  parameter int CHK_CYC     = 6,
  parameter int WAKE_CYC    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_cycle_i,
  input  logic int_req_i,
  input  logic serirq_act_i,
  input  logic req_line_i,
  output logic req_drive_o,
  output logic req_oe_o,
  output logic clk_stop_no
);
  bcg_state_e state;
  logic       line_sync;
  logic       any_act;
  logic       idle_done;
  logic       in_run;

  assign any_act = bus_cycle_i | int_req_i | serirq_act_i;
  assign in_run  = (state == ST_RUN);

  bcg_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b0)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (req_line_i),
    .q_o    (line_sync)
  );

  bcg_idle_cnt #(
    .IDLE_CYC (IDLE_CYC)
  ) u_idle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (in_run),
    .act_i    (any_act),
    .expire_o (idle_done)
  );

  bcg_fsm #(
    .CHK_CYC     (CHK_CYC),
    .WAKE_CYC    (WAKE_CYC),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idle_done_i (idle_done),
    .act_i       (any_act),
    .line_s_i    (line_sync),
    .state_o     (state)
  );

  assign req_oe_o    = (state == ST_RUN) || (state == ST_DEASSERT) || (state == ST_WAKE);
  assign req_drive_o = (state == ST_DEASSERT);
  assign clk_stop_no = !((state == ST_STOP) || (state == ST_WAKE));
endmodule

// File: rtl/bcg_checker.sv
module bcg_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic int_req_i,
  input logic req_drive_o,
  input logic req_oe_o,
  input logic clk_stop_no,
  input logic line_sync
);
  // R2: high drive lasts one clock
  a_r2_high_one_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_oe_o && req_drive_o) |=> !req_drive_o);

  // R4: internal request keeps line driven low before stop
  a_r4_int_req_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_req_i && clk_stop_no) |=> (req_oe_o && !req_drive_o && clk_stop_no));

  // R5: stop only issued while released
  a_r5_stop_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_stop_no) |-> (!req_oe_o && $past(!req_oe_o)));

  // R7: drive low one clock after sampled low
  a_r7_wake_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_stop_no && !req_oe_o && !line_sync) |=> (req_oe_o && !req_drive_o && !clk_stop_no));

  // R7: stop released two clocks after sampled low
  a_r7_wake_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_stop_no && !req_oe_o && !line_sync) |=> ##1 clk_stop_no);

  // R5: never drive high while stopped
  a_r5_no_high_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_stop_no |-> !req_drive_o);
endmodule

bind bus_clk_gate_ctrl bcg_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .int_req_i   (int_req_i),
  .req_drive_o (req_drive_o),
  .req_oe_o    (req_oe_o),
  .clk_stop_no (clk_stop_no),
  .line_sync   (line_sync)
);

// File: tb/bus_clk_gate_ctrl_tb.sv
module bus_clk_gate_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IDLE = 29;
  localparam int CHK  = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bus_cycle = 1'b0, int_req = 1'b0, serirq = 1'b0;
  logic ext_low = 1'b0;
  logic drv, oe, stop_n;
  logic line;
  int   n_chk = 0, n_err = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // wired-AND open-drain pad with pull-up
  assign line = (oe ? drv : 1'b1) & ~ext_low;

  bus_clk_gate_ctrl u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .bus_cycle_i  (bus_cycle),
    .int_req_i    (int_req),
    .serirq_act_i (serirq),
    .req_line_i   (line),
    .req_drive_o  (drv),
    .req_oe_o     (oe),
    .clk_stop_no  (stop_n)
  );

  // expected outputs o clocks into an idle period
  function automatic logic f_oe(int o);     return o <= IDLE; endfunction
  function automatic logic f_drv(int o);    return o == IDLE; endfunction
  function automatic logic f_stop_n(int o); return o < IDLE + 1 + CHK; endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_out(string req, logic e_oe, logic e_drv, logic e_stop);
    chk({req, " oe"}, int'(oe), int'(e_oe));
    chk({req, " drive"}, int'(drv), int'(e_drv));
    chk({req, " stop_n"}, int'(stop_n), int'(e_stop));
  endtask

  // step from offset 'from' to 'to', checking every cycle
  task automatic idle_run(int from, int to, string req);
    for (int o = from + 1; o <= to; o++) begin
      step();
      chk_out(req, f_oe(o), f_drv(o), f_stop_n(o));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    // R1 reset state
    repeat (3) step();
    chk_out("R1", 1'b1, 1'b0, 1'b1);
    @(negedge clk); rst_ni = 1'b1; #1;
    chk_out("R1", 1'b1, 1'b0, 1'b1);

    // R2/R5 from reset to stop
    idle_run(0, 36, "R2_R5");

    // R7 external restart: pin low at S, sampled at S+2
    ext_low = 1'b1;
    step(); chk("R7 S+1 stop_n", int'(stop_n), 0);
    step(); chk("R7 S+2 stop_n", int'(stop_n), 0);
    step(); chk_out("R7 S+3", 1'b1, 1'b0, 1'b0);
    ext_low = 1'b0;
    step(); chk_out("R7 S+4", 1'b1, 1'b0, 1'b1);

    // R6 veto in window: pin low at first window clock
    idle_run(0, 30, "R3");
    ext_low = 1'b1;
    step(); chk("R6 o31 oe", int'(oe), 0);
    step(); chk("R6 o32 oe", int'(oe), 0);
    step(); chk_out("R6 o33", 1'b1, 1'b0, 1'b1);
    ext_low = 1'b0;
    idle_run(0, 3, "R6 no stop");

    // R4/R8 int_req in window
    idle_run(3, 31, "R2");
    int_req = 1'b1;
    step(); chk_out("R4_R8 window", 1'b1, 1'b0, 1'b1);
    int_req = 1'b0;

    // R8 serirq during high drive
    idle_run(0, 29, "R2");
    serirq = 1'b1;
    step(); chk_out("R8 deassert abort", 1'b1, 1'b0, 1'b1);
    serirq = 1'b0;

    // R9 int_req while stopped
    idle_run(0, 36, "R5");
    int_req = 1'b1;
    step(); chk_out("R9 S+1", 1'b1, 1'b0, 1'b0);
    int_req = 1'b0;
    step(); chk_out("R9 S+2", 1'b1, 1'b0, 1'b1);

    // R3 random activity pulses and idle gaps
    for (int ep = 0; ep < 40; ep++) begin
      int sel = int'($urandom % 3);
      int gap = 1 + int'($urandom % 35);
      bus_cycle = (sel == 0);
      int_req   = (sel == 1);
      serirq    = (sel == 2);
      step();
      bus_cycle = 1'b0; int_req = 1'b0; serirq = 1'b0;
      chk_out("R3 pulse", 1'b1, 1'b0, 1'b1);
      idle_run(0, gap, "R3");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule